// File: doc/BRIEF.md
# Fast Command Frame Decoder

This block sits behind a gigabit MAC receiver, after the frame check sequence has been verified. It watches a byte-wide stream of raw Ethernet II frames, with start, end and error markers, and separates out timing-critical fast-command frames. A fast-command frame has the type field 0x0809. Its fixed-offset payload holds a magic word, a target link number, a comma byte and a flags byte, all protected by per-field even parity. When a valid command arrives, the block raises a one-cycle strobe on one selected downstream link, or on every link for a broadcast. The strobe is qualified by the comma and flags bytes.

Every frame with any other type value is forwarded unchanged to the normal receive queue port. Because the decision rests on the type field, the forwarded stream is delayed by a fixed fourteen-stage line. Fast-command frames never reach that port. A frame that cannot be acted on produces an error pulse, or in some cases nothing at all (see R6 to R8).

Top module: `fastcmd_decoder`

## Requirements
- R1: A frame whose bytes 12 and 13 (counting from byte 0 at the start marker) are 0x08 and 0x09 is a fast-command frame and none of its bytes appear on the forwarding port. Frames with any other type value (for example 0x0810 or 0x0811) are forwarded.
- R2: Forwarded frames appear on the out_* port with identical bytes and identical start, end and error markers, exactly 14 clock cycles after the matching input byte. This includes frames shorter than 14 bytes. Input bytes of one frame arrive on consecutive cycles.
- R3: Fast-command fields are big-endian at fixed offsets. The command word is byte 14 (high) and byte 15 (low), and it must equal 0xFA57. The target link is byte 16, the comma byte is byte 17 and the flags byte is byte 18. The parity word is bytes 19 (high) and 20 (low), and its check bits are bits 4:0 of byte 20.
- R4: With a target value below NPORT, exactly bit <target> of cmd_stb is set. It is set for one cycle, with cmd_comma and cmd_flags carrying bytes 17 and 18 in that same cycle.
- R5: A target value of 0xFF sets every bit of cmd_stb for one cycle.
- R6: Each parity bit makes its byte's count of ones even: bit 0 covers byte 15, bit 1 byte 14, bit 2 byte 16, bit 3 byte 17 and bit 4 byte 18. On any mismatch, no strobe is issued and parity_err pulses for one cycle. This check takes priority over R7.
- R7: With correct parity, a command word other than 0xFA57, or a target that is neither 0xFF nor below NPORT, gives no strobe and a one-cycle bad_cmd pulse.
- R8: A fast-command frame whose end byte carries the error flag, or that ends before byte 20, is dropped silently: no strobe, no parity_err and no bad_cmd.
- R9: Bytes after byte 20 (padding) have no effect on the command, whatever their values or number.
- R10: Strobes and error pulses appear in the second cycle after the cycle that presents the frame's end byte.
- R11: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_err | input | 1 | Frame error, qualified by in_eof |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | Forwarded first byte |
| out_eof | output | 1 | Forwarded last byte |
| out_err | output | 1 | Forwarded frame error |
| cmd_stb | output | NPORT | One-cycle command strobe per downstream link |
| cmd_comma | output | 8 | Comma byte of the issued command |
| cmd_flags | output | 8 | Flags byte of the issued command |
| parity_err | output | 1 | Pulse: fast command rejected on parity |
| bad_cmd | output | 1 | Pulse: wrong magic word or target out of range |

## Verification
The bench targets the edges of the frame classification and of the command checks. A frame whose type differs from the fast value in a single byte must be forwarded. A wrongly decoded type would swallow data frames or leak fast frames. Back-to-back frames probe whether the drop mark bleeds into the following data frame, which would truncate it. The bench also covers frames that end exactly at the last parity byte, one byte before it, and with the error flag set. A bad length threshold or ignoring the error flag would show up as a spurious or missing strobe. Parity errors are planted on single fields. A swapped bit-to-byte mapping or a wrong priority between parity and magic checks would raise the wrong pulse. The bench also checks the out-of-range target, the broadcast value and the fixed 14-cycle and 2-cycle latencies.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam logic [15:0] FAST_TYPE = 16'h0809;
    localparam logic [15:0] CMD_MAGIC = 16'hFA57;
    localparam logic [7:0]  PORT_ALL  = 8'hFF;
    localparam int          HDR_LEN   = 14;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       sof;
        logic       eof;
        logic       err;
    } beat_t;

    typedef struct packed {
        logic       vld;
        logic       drop;
        logic [7:0] data;
        logic       sof;
        logic       eof;
        logic       err;
    } stage_t;

    typedef struct packed {
        logic [7:0] cmd_hi;
        logic [7:0] cmd_lo;
        logic [7:0] port;
        logic [7:0] comma;
        logic [7:0] flags;
        logic [4:0] par;
    } fields_t;

endpackage

// File: rtl/fcd_delay_line.sv
module fcd_delay_line
    import fcd_pkg::*;
#(
    parameter int DEPTH = HDR_LEN
) (
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t in_i,
    input  logic  mark_i,
    output beat_t out_o
);

    typedef struct packed {
        stage_t [DEPTH-1:0] stg;
        logic               in_fast;
    } dl_t;

    dl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0].vld  = in_i.valid;
        s_d.stg[0].drop = mark_i | (s_q.in_fast & ~in_i.sof);
        s_d.stg[0].data = in_i.data;
        s_d.stg[0].sof  = in_i.sof;
        s_d.stg[0].eof  = in_i.eof;
        s_d.stg[0].err  = in_i.err;
        for (int i = 1; i < DEPTH; i++) begin
            s_d.stg[i]      = s_q.stg[i-1];
            s_d.stg[i].drop = s_q.stg[i-1].drop | mark_i;
        end
        if (in_i.valid && in_i.eof) begin
            s_d.in_fast = 1'b0;
        end else if (mark_i) begin
            s_d.in_fast = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic pass;
    assign pass       = s_q.stg[DEPTH-1].vld & ~s_q.stg[DEPTH-1].drop;
    assign out_o.valid = pass;
    assign out_o.data  = pass ? s_q.stg[DEPTH-1].data : 8'h00;
    assign out_o.sof   = pass & s_q.stg[DEPTH-1].sof;
    assign out_o.eof   = pass & s_q.stg[DEPTH-1].eof;
    assign out_o.err   = pass & s_q.stg[DEPTH-1].err;

    // R1
    drop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_i |=> s_q.stg[DEPTH-1].drop);

endmodule

// File: rtl/fcd_field_capture.sv
module fcd_field_capture
    import fcd_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  beat_t   in_i,
    output logic    mark_o,
    output logic    done_o,
    output logic    ok_o,
    output fields_t fld_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] IDX_THI  = CNT_W'(12);
    localparam logic [CNT_W-1:0] IDX_TLO  = CNT_W'(13);
    localparam logic [CNT_W-1:0] IDX_CHI  = CNT_W'(14);
    localparam logic [CNT_W-1:0] IDX_CLO  = CNT_W'(15);
    localparam logic [CNT_W-1:0] IDX_PORT = CNT_W'(16);
    localparam logic [CNT_W-1:0] IDX_COM  = CNT_W'(17);
    localparam logic [CNT_W-1:0] IDX_FLG  = CNT_W'(18);
    localparam logic [CNT_W-1:0] IDX_PAR  = CNT_W'(20);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       type_hi;
        logic             fast;
        fields_t          fld;
        logic             done;
        logic             ok;
    } fc_t;

    fc_t s_d, s_q;
    logic [CNT_W-1:0] idx;

    assign idx    = in_i.sof ? '0 : s_q.cnt;
    assign mark_o = in_i.valid && (idx == IDX_TLO) &&
                    (s_q.type_hi == FAST_TYPE[15:8]) && (in_i.data == FAST_TYPE[7:0]);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.ok   = 1'b0;
        if (in_i.valid) begin
            s_d.cnt = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
            unique case (idx)
                IDX_THI:  s_d.type_hi    = in_i.data;
                IDX_CHI:  s_d.fld.cmd_hi = in_i.data;
                IDX_CLO:  s_d.fld.cmd_lo = in_i.data;
                IDX_PORT: s_d.fld.port   = in_i.data;
                IDX_COM:  s_d.fld.comma  = in_i.data;
                IDX_FLG:  s_d.fld.flags  = in_i.data;
                IDX_PAR:  s_d.fld.par    = in_i.data[4:0];
                default: ;
            endcase
            if (in_i.sof) s_d.fast = 1'b0;
            if (mark_o)   s_d.fast = 1'b1;
            if (in_i.eof) begin
                s_d.done = 1'b1;
                s_d.ok   = ~in_i.err & s_q.fast & (idx >= IDX_PAR);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
    assign ok_o   = s_q.ok;
    assign fld_o  = s_q.fld;

    // R10
    done_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(in_i.valid && in_i.eof));

endmodule

// File: rtl/fcd_cmd_issue.sv
module fcd_cmd_issue
    import fcd_pkg::*;
#(
    parameter int NPORT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             ok_i,
    input  fields_t          fld_i,
    output logic [NPORT-1:0] stb_o,
    output logic [7:0]       comma_o,
    output logic [7:0]       flags_o,
    output logic             perr_o,
    output logic             bad_o
);

    localparam logic [7:0] PORT_LIMIT = 8'(NPORT);

    typedef struct packed {
        logic [NPORT-1:0] stb;
        logic [7:0]       comma;
        logic [7:0]       flags;
        logic             perr;
        logic             bad;
    } iss_t;

    iss_t r_d, r_q;
    logic [4:0] par_exp;
    logic       par_ok, magic_ok, bcast, port_ok, cand, fire;

    always_comb begin
        par_exp  = {^fld_i.flags, ^fld_i.comma, ^fld_i.port, ^fld_i.cmd_hi, ^fld_i.cmd_lo};
        par_ok   = (fld_i.par == par_exp);
        magic_ok = ({fld_i.cmd_hi, fld_i.cmd_lo} == CMD_MAGIC);
        bcast    = (fld_i.port == PORT_ALL);
        port_ok  = bcast || (fld_i.port < PORT_LIMIT);
        cand     = done_i & ok_i;
        fire     = cand & par_ok & magic_ok & port_ok;

        r_d       = r_q;
        r_d.perr  = cand & ~par_ok;
        r_d.bad   = cand & par_ok & ~(magic_ok & port_ok);
        for (int i = 0; i < NPORT; i++) begin
            r_d.stb[i] = fire & (bcast | (fld_i.port == 8'(i)));
        end
        if (fire) begin
            r_d.comma = fld_i.comma;
            r_d.flags = fld_i.flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stb_o   = r_q.stb;
    assign comma_o = r_q.comma;
    assign flags_o = r_q.flags;
    assign perr_o  = r_q.perr;
    assign bad_o   = r_q.bad;

    // R4 R5
    stb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|r_q.stb) |-> ($countones(r_q.stb) == 1 || (&r_q.stb)));

    // R4
    stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|r_q.stb) |=> !(|r_q.stb));

    // R6 R7
    no_cmd_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.perr || r_q.bad) |-> !(|r_q.stb));

    // R6
    one_error_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.perr && r_q.bad));

endmodule

// File: rtl/fastcmd_decoder.sv
module fastcmd_decoder
    import fcd_pkg::*;
#(
    parameter int NPORT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_err,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_err,
    output logic [NPORT-1:0] cmd_stb,
    output logic [7:0]       cmd_comma,
    output logic [7:0]       cmd_flags,
    output logic             parity_err,
    output logic             bad_cmd
);

    beat_t   in_b, out_b;
    logic    mark, done, ok;
    fields_t fld;

    assign in_b.valid = in_valid;
    assign in_b.data  = in_data;
    assign in_b.sof   = in_sof;
    assign in_b.eof   = in_eof;
    assign in_b.err   = in_err;

    fcd_field_capture #(.CNT_W(5)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (in_b),
        .mark_o (mark),
        .done_o (done),
        .ok_o   (ok),
        .fld_o  (fld)
    );

    fcd_delay_line #(.DEPTH(HDR_LEN)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (in_b),
        .mark_i (mark),
        .out_o  (out_b)
    );

    fcd_cmd_issue #(.NPORT(NPORT)) u_iss (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .ok_i    (ok),
        .fld_i   (fld),
        .stb_o   (cmd_stb),
        .comma_o (cmd_comma),
        .flags_o (cmd_flags),
        .perr_o  (parity_err),
        .bad_o   (bad_cmd)
    );

    assign out_valid = out_b.valid;
    assign out_data  = out_b.data;
    assign out_sof   = out_b.sof;
    assign out_eof   = out_b.eof;
    assign out_err   = out_b.err;

endmodule

// File: tb/sim_fastcmd_decoder.sv
module sim_fastcmd_decoder;

    localparam int NP = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          out_valid, out_sof, out_eof, out_err;
    logic [7:0]    out_data;
    logic [NP-1:0] cmd_stb;
    logic [7:0]    cmd_comma, cmd_flags;
    logic          parity_err, bad_cmd;

    always #5 clk = ~clk;

    fastcmd_decoder #(.NPORT(NP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err),
        .cmd_stb(cmd_stb), .cmd_comma(cmd_comma), .cmd_flags(cmd_flags),
        .parity_err(parity_err), .bad_cmd(bad_cmd)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [7:0] frm [0:79];
    int flen;
    logic [7:0] outbuf [0:127];
    int outn, out_eof_n, out_err_n, stb_n, perr_n, bad_n;
    int in_sof_cyc, in_eof_cyc, out_sof_cyc, stb_cyc, err_cyc;
    logic [NP-1:0] last_stb;
    logic [7:0] last_comma, last_flags;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (in_valid && in_sof) in_sof_cyc = cyc;
        if (in_valid && in_eof) in_eof_cyc = cyc;
        if (out_valid) begin
            if (outn < 128) outbuf[outn] = out_data;
            if (out_sof) out_sof_cyc = cyc;
            if (out_eof) out_eof_n++;
            if (out_err) out_err_n++;
            outn++;
        end
        if (|cmd_stb) begin
            stb_n++; last_stb = cmd_stb; last_comma = cmd_comma; last_flags = cmd_flags; stb_cyc = cyc;
        end
        if (parity_err) begin perr_n++; err_cyc = cyc; end
        if (bad_cmd) begin bad_n++; err_cyc = cyc; end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        outn = 0; out_eof_n = 0; out_err_n = 0; stb_n = 0; perr_n = 0; bad_n = 0;
        last_stb = '0; in_sof_cyc = -1; in_eof_cyc = -1; out_sof_cyc = -1; stb_cyc = -1; err_cyc = -1;
    endtask

    task automatic send(input bit errflag);
        for (int i = 0; i < flen; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = frm[i];
            in_sof = (i == 0); in_eof = (i == flen - 1);
            in_err = (i == flen - 1) && errflag;
        end
    endtask

    task automatic idle_wait(input int n);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_data = 8'h00;
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic build(input logic [15:0] typ, input logic [15:0] magic, input logic [7:0] port,
                         input logic [7:0] comma, input logic [7:0] flags, input logic [4:0] par_flip,
                         input logic [7:0] padseed);
        logic [4:0] p;
        for (int i = 0; i < 6; i++) frm[i] = 8'hFF;
        for (int i = 6; i < 12; i++) frm[i] = 8'(8'h20 + i);
        frm[12] = typ[15:8]; frm[13] = typ[7:0];
        frm[14] = magic[15:8]; frm[15] = magic[7:0];
        frm[16] = port; frm[17] = comma; frm[18] = flags;
        p[0] = ^frm[15]; p[1] = ^frm[14]; p[2] = ^frm[16]; p[3] = ^frm[17]; p[4] = ^frm[18];
        frm[19] = 8'h00; frm[20] = {3'b000, p ^ par_flip};
        for (int i = 21; i < 80; i++) frm[i] = 8'(padseed + 8'(i * 7));
        flen = 65;
    endtask

    task automatic check_pass(input string req, input bit errflag);
        int mism = 0;
        for (int i = 0; i < flen; i++) if (outbuf[i] != frm[i]) mism++;
        chk(req, "forwarded byte count", outn, flen);
        chk(req, "forwarded byte mismatches", mism, 0);
        chk(req, "forwarded end markers", out_eof_n, 1);
        chk(req, "forwarded error markers", out_err_n, errflag ? 1 : 0);
        chk("R2", "forwarding latency", out_sof_cyc - in_sof_cyc, 14);
        chk("R1", "no strobe on forwarded frame", stb_n, 0);
    endtask

    task automatic t_reset();
        #2;
        chk("R11", "outputs zero in reset", {out_valid, out_sof, out_eof, out_err, out_data, cmd_stb,
             cmd_comma, cmd_flags, parity_err, bad_cmd}, 0);
        repeat (2) @(posedge clk); #1; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11", "outputs zero after reset", {out_valid, out_data, cmd_stb, cmd_comma, cmd_flags,
             parity_err, bad_cmd}, 0);
    endtask

    task automatic t_single();
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd3, 8'hBC, 8'h5A, 5'd0, 8'h11);
        send(1'b0); idle_wait(24);
        chk("R4", "single strobe count", stb_n, 1);
        chk("R4", "strobe vector", last_stb, 10'b00_0000_1000);
        chk("R4", "comma byte", last_comma, 8'hBC);
        chk("R3", "flags byte", last_flags, 8'h5A);
        chk("R10", "strobe delay after end", stb_cyc - in_eof_cyc, 2);
        chk("R1", "fast frame not forwarded", outn, 0);
        chk("R6", "no parity error", perr_n + bad_n, 0);
    endtask

    task automatic t_last_port();
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd9, 8'h1C, 8'hFF, 5'd0, 8'h90);
        send(1'b0); idle_wait(24);
        chk("R4", "highest port strobe", last_stb, 10'b10_0000_0000);
        chk("R4", "highest port count", stb_n, 1);
    endtask

    task automatic t_bcast();
        clear_mon();
        build(16'h0809, 16'hFA57, 8'hFF, 8'h7C, 8'h01, 5'd0, 8'h33);
        send(1'b0); idle_wait(24);
        chk("R5", "broadcast strobe vector", last_stb, {NP{1'b1}});
        chk("R5", "broadcast strobe count", stb_n, 1);
        chk("R5", "broadcast comma", last_comma, 8'h7C);
    endtask

    task automatic t_parity();
        logic [4:0] flips [0:4];
        flips[0] = 5'b00001; flips[1] = 5'b00010; flips[2] = 5'b00100; flips[3] = 5'b01000; flips[4] = 5'b10000;
        for (int k = 0; k < 5; k++) begin
            clear_mon();
            build(16'h0809, 16'hFA57, 8'd2, 8'h3C, 8'h80, flips[k], 8'h44);
            send(1'b0); idle_wait(24);
            chk("R6", $sformatf("parity bit %0d strobe suppressed", k), stb_n, 0);
            chk("R6", $sformatf("parity bit %0d error pulse", k), perr_n, 1);
            chk("R6", $sformatf("parity bit %0d no bad_cmd", k), bad_n, 0);
        end
        clear_mon();
        build(16'h0809, 16'h1234, 8'd2, 8'h3C, 8'h80, 5'b00010, 8'h44);
        send(1'b0); idle_wait(24);
        chk("R6", "parity wins over magic", perr_n * 10 + bad_n, 10);
        chk("R10", "error pulse delay", err_cyc - in_eof_cyc, 2);
    endtask

    task automatic t_bad();
        clear_mon();
        build(16'h0809, 16'hFA56, 8'd1, 8'h3C, 8'h00, 5'd0, 8'h55);
        send(1'b0); idle_wait(24);
        chk("R7", "wrong magic strobe", stb_n, 0);
        chk("R7", "wrong magic bad_cmd", bad_n, 1);
        chk("R7", "wrong magic no parity error", perr_n, 0);
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd10, 8'h3C, 8'h00, 5'd0, 8'h55);
        send(1'b0); idle_wait(24);
        chk("R7", "target out of range strobe", stb_n, 0);
        chk("R7", "target out of range bad_cmd", bad_n, 1);
    endtask

    task automatic t_silent();
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd4, 8'h3C, 8'h00, 5'd0, 8'h66);
        send(1'b1); idle_wait(24);
        chk("R8", "error-flagged frame pulses", stb_n + perr_n + bad_n, 0);
        chk("R1", "error-flagged fast frame not forwarded", outn, 0);
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd4, 8'h3C, 8'h00, 5'd0, 8'h66);
        flen = 20;
        send(1'b0); idle_wait(24);
        chk("R8", "frame ending at byte 19 pulses", stb_n + perr_n + bad_n, 0);
        chk("R1", "short fast frame not forwarded", outn, 0);
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd4, 8'h3C, 8'h00, 5'd0, 8'h66);
        flen = 21;
        send(1'b0); idle_wait(24);
        chk("R9", "frame ending at byte 20 fires", stb_n, 1);
        chk("R9", "frame ending at byte 20 strobe", last_stb, 10'b00_0001_0000);
    endtask

    task automatic t_padding();
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd6, 8'hF7, 8'hA5, 5'd0, 8'hFA);
        for (int i = 21; i < 80; i++) frm[i] = (i % 2 == 0) ? 8'h08 : 8'h09;
        flen = 80;
        send(1'b0); idle_wait(24);
        chk("R9", "odd padding strobe", last_stb, 10'b00_0100_0000);
        chk("R9", "odd padding count", stb_n, 1);
        chk("R9", "odd padding flags", last_flags, 8'hA5);
    endtask

    task automatic t_forward();
        clear_mon();
        build(16'h0810, 16'hFA57, 8'd1, 8'hBC, 8'h00, 5'd0, 8'h77);
        flen = 30;
        send(1'b0); idle_wait(24);
        check_pass("R1", 1'b0);
        clear_mon();
        build(16'h0811, 16'hFA57, 8'd1, 8'hBC, 8'h00, 5'd0, 8'h78);
        send(1'b1); idle_wait(24);
        check_pass("R2", 1'b1);
        clear_mon();
        build(16'h0909, 16'hFA57, 8'd1, 8'hBC, 8'h00, 5'd0, 8'h79);
        send(1'b0); idle_wait(24);
        check_pass("R1", 1'b0);
        clear_mon();
        build(16'h0810, 16'hFA57, 8'd1, 8'hBC, 8'h00, 5'd0, 8'h7A);
        flen = 8;
        send(1'b0); idle_wait(24);
        check_pass("R2", 1'b0);
    endtask

    task automatic t_back_to_back();
        clear_mon();
        build(16'h0809, 16'hFA57, 8'd0, 8'h3C, 8'h42, 5'd0, 8'h12);
        send(1'b0);
        build(16'h0811, 16'h0000, 8'd0, 8'h00, 8'h00, 5'd0, 8'h13);
        flen = 40;
        send(1'b0); idle_wait(24);
        chk("R4", "back-to-back strobe", last_stb, 10'b00_0000_0001);
        chk("R4", "back-to-back strobe count", stb_n, 1);
        chk("R2", "data frame after fast frame length", outn, 40);
        chk("R2", "data frame first byte", outbuf[0], 8'hFF);
        chk("R2", "data frame last byte", outbuf[39], frm[39]);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        clear_mon();
        t_reset();
        t_single();
        t_last_port();
        t_bcast();
        t_parity();
        t_bad();
        t_silent();
        t_padding();
        t_forward();
        t_back_to_back();
        report();
        $finish;
    end

endmodule